// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Selector

This block decides which of sixteen interrupt sources is serviced next. Sources raise requests by pulsing their bit on `src_raise`; each request stays pending until the selector acknowledges it. A source takes part in arbitration only while its bit on `src_enable` is set. A sixteen-bit tier register uses the same bit-per-source layout as the enable vector. When a source's bit is set in this register, the source moves from the normal tier into the promoted tier.

Any eligible source in the promoted tier beats every eligible source in the normal tier. Inside either tier, the fixed default ranking still applies: a larger source index wins. The tier register is written one byte at a time, which suits an 8-bit register window. Its reset value of zero gives the plain fixed ranking. The result is a registered request flag and the index of the winning source. Acknowledging the request retires the pending bit of that winner.

Top module: `irq_prio_sel`

## Requirements
- R1: Reset clears every pending bit and the tier register, and drives `irq_req` to 0 and `irq_id` to 0.
- R2: A source is eligible only when its pending bit is set and its `src_enable` bit is 1. Pending but disabled sources are never reported, and `irq_req` is 1 exactly when at least one source is eligible.
- R3: If no eligible source is in the promoted tier, the eligible source with the largest index is reported.
- R4: An eligible source whose tier bit is 1 is reported ahead of every eligible source whose tier bit is 0.
- R5: Among eligible promoted sources, the largest index wins.
- R6: A tier write with `prio_wr_sel` = 0 loads `prio_wr_data` into tier bits 7:0, and with `prio_wr_sel` = 1 into bits 15:8. The other byte is left unchanged.
- R7: A pulse on `src_raise[i]` sets pending bit i. The bit stays set until an acknowledge clears it.
- R8: `ack` while `irq_req` is 1 clears the pending bit of the source shown on `irq_id`. `ack` while `irq_req` is 0 changes nothing.
- R9: `irq_req` and `irq_id` are registered. After a rising edge they reflect the pending bits and tier register as they stood before that edge, and `src_enable` as sampled at that edge.
- R10: If a source is raised in the same cycle that its pending bit is acknowledged, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_raise | input | 16 | One-cycle request pulse per source |
| src_enable | input | 16 | Per-source enable, 1 = may be selected |
| prio_wr_en | input | 1 | Tier register byte write strobe |
| prio_wr_sel | input | 1 | Byte select: 0 = bits 7:0, 1 = bits 15:8 |
| prio_wr_data | input | 8 | Byte written into the tier register |
| ack | input | 1 | Acknowledge of the currently reported source |
| irq_req | output | 1 | At least one source is eligible |
| irq_id | output | 4 | Index of the winning source |

## Verification
A change on `src_enable` shows up on the outputs at the very next rising edge. A raise pulse, a tier write or an acknowledge passes through one register first, so its effect appears one edge later. Arbitration therefore always sees the old pending and tier state. The bench keeps a behavioural model that is updated on each rising edge from the same input values the design samples. Inputs are driven and outputs compared on the falling edge, so every result is checked in the cycle it is due. Directed sequences cover same-edge enable changes, byte writes, idle acknowledges and raise-versus-acknowledge collisions, and a long randomised run follows them.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        TIER_LOW  = 1'b0,
        TIER_HIGH = 1'b1
    } tier_e;
endpackage

// File: rtl/irqp_prio_reg.sv
module irqp_prio_reg #(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned SELW  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [SELW-1:0]              wr_sel_i,
    input  logic [irqp_pkg::BYTE_W-1:0]  wr_data_i,
    output logic [N_SRC-1:0]             prio_o
);
    import irqp_pkg::*;

    localparam int unsigned NBYTES = N_SRC / BYTE_W;

    logic [N_SRC-1:0] prio_d, prio_q;

    always_comb begin
        prio_d = prio_q;
        if (wr_en_i) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_sel_i == SELW'(b)) begin
                    prio_d[b*BYTE_W +: BYTE_W] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prio_q <= '0;
        else        prio_q <= prio_d;
    end

    assign prio_o = prio_q;

    // A write aimed at another byte leaves this one untouched (R6)
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_chk
        assert_byte_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i || wr_sel_i != SELW'(b)) |=> $stable(prio_q[b*BYTE_W +: BYTE_W]));
    end
endmodule

// File: rtl/irqp_pend_reg.sv
module irqp_pend_reg #(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raise_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr_i) | raise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit_chk
        assert_pend_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
        assert_raise_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            raise_i[i] |=> pend_q[i]);
    end
endmodule

// File: rtl/irqp_pick.sv
module irqp_pick #(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned IDW   = 4
) (
    input  logic [N_SRC-1:0]  elig_i,
    input  logic [N_SRC-1:0]  hi_i,
    output logic              valid_o,
    output irqp_pkg::tier_e   tier_o,
    output logic [IDW-1:0]    idx_o
);
    import irqp_pkg::*;

    for (genvar t = 0; t < 2; t++) begin : g_tier
        logic [N_SRC-1:0] vec;
        logic             any;
        logic [IDW-1:0]   idx;

        assign vec = elig_i & ((t == 1) ? hi_i : ~hi_i);

        always_comb begin
            any = |vec;
            idx = '0;
            for (int i = 0; i < N_SRC; i++) begin
                if (vec[i]) idx = IDW'(i);
            end
        end
    end

    always_comb begin
        valid_o = g_tier[1].any | g_tier[0].any;
        if (g_tier[1].any) begin
            tier_o = TIER_HIGH;
            idx_o  = g_tier[1].idx;
        end else begin
            tier_o = TIER_LOW;
            idx_o  = g_tier[0].idx;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int unsigned N_SRC = 16,
    localparam int unsigned IDW  = $clog2(N_SRC),
    localparam int unsigned NBYT = N_SRC / irqp_pkg::BYTE_W,
    localparam int unsigned SELW = (NBYT > 1) ? $clog2(NBYT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0]            src_raise,
    input  logic [N_SRC-1:0]            src_enable,
    input  logic                        prio_wr_en,
    input  logic [SELW-1:0]             prio_wr_sel,
    input  logic [irqp_pkg::BYTE_W-1:0] prio_wr_data,
    input  logic                        ack,
    output logic                        irq_req,
    output logic [IDW-1:0]              irq_id
);
    import irqp_pkg::*;

    typedef struct packed {
        logic           req;
        logic [IDW-1:0] id;
    } win_t;

    win_t st_d, st_q;

    logic [N_SRC-1:0] pend_q, prio_q, elig, clr;
    logic             pick_valid;
    tier_e            pick_tier;
    logic [IDW-1:0]   pick_idx;

    irqp_prio_reg #(.N_SRC(N_SRC), .SELW(SELW)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (prio_wr_en),
        .wr_sel_i (prio_wr_sel),
        .wr_data_i(prio_wr_data),
        .prio_o   (prio_q)
    );

    irqp_pend_reg #(.N_SRC(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise_i(src_raise),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    assign elig = pend_q & src_enable;

    irqp_pick #(.N_SRC(N_SRC), .IDW(IDW)) u_pick (
        .elig_i (elig),
        .hi_i   (prio_q),
        .valid_o(pick_valid),
        .tier_o (pick_tier),
        .idx_o  (pick_idx)
    );

    always_comb begin
        clr = '0;
        if (ack && st_q.req) clr[st_q.id] = 1'b1;
        st_d.req = pick_valid;
        st_d.id  = pick_valid ? pick_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req = st_q.req;
    assign irq_id  = st_q.id;

    // Peers of the chosen source in its own tier, for the ordering check
    logic [N_SRC-1:0] peers;
    assign peers = elig & ((pick_tier == TIER_HIGH) ? prio_q : ~prio_q);

    assert_pick_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> elig[pick_idx]);
    assert_top_in_tier_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ($countones(peers >> pick_idx) == 1));
    assert_high_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && (|(elig & prio_q))) |-> prio_q[pick_idx]);
    assert_ack_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.req && !src_raise[st_q.id]) |=> !pend_q[$past(st_q.id)]);
endmodule

// File: tb/tb_irq_prio_sel.sv
module tb_irq_prio_sel;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] src_raise, src_enable;
    logic        prio_wr_en, prio_wr_sel;
    logic [7:0]  prio_wr_data;
    logic        ack;
    logic        irq_req;
    logic [3:0]  irq_id;

    always #10 clk = ~clk;

    irq_prio_sel dut (
        .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_enable(src_enable),
        .prio_wr_en(prio_wr_en), .prio_wr_sel(prio_wr_sel), .prio_wr_data(prio_wr_data),
        .ack(ack), .irq_req(irq_req), .irq_id(irq_id)
    );

    int errors = 0;
    int checks = 0;

    // Behavioural reference: scores each eligible source, promoted ones get a bonus
    logic [N-1:0] m_pend, m_prio, m_clr;
    logic         m_req;
    int           m_id, best, bid;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_prio = '0; m_req = 1'b0; m_id = 0;
        end else begin
            best = -1; bid = 0;
            for (int i = 0; i < N; i++) begin
                if (m_pend[i] && src_enable[i] && (i + (m_prio[i] ? N : 0)) > best) begin
                    best = i + (m_prio[i] ? N : 0);
                    bid  = i;
                end
            end
            m_clr = '0;
            if (ack && m_req) m_clr[m_id] = 1'b1;
            m_pend = (m_pend & ~m_clr) | src_raise;
            if (prio_wr_en) begin
                if (prio_wr_sel) m_prio[15:8] = prio_wr_data;
                else             m_prio[7:0]  = prio_wr_data;
            end
            m_req = (best >= 0);
            m_id  = m_req ? bid : 0;
        end
    end

    task automatic compare(input string tag);
        checks++;
        if (irq_req !== m_req) begin
            errors++;
            $display("FAIL %s R9 irq_req actual=%0b expected=%0b", tag, irq_req, m_req);
        end
        if (m_req) begin
            checks++;
            if (irq_id !== 4'(m_id)) begin
                errors++;
                $display("FAIL %s R9 irq_id actual=%0d expected=%0d", tag, irq_id, m_id);
            end
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        compare(tag);
        src_raise  = '0;
        prio_wr_en = 1'b0;
        ack        = 1'b0;
    endtask

    task automatic wr_tier(input logic sel, input logic [7:0] val, input string tag);
        prio_wr_en = 1'b1; prio_wr_sel = sel; prio_wr_data = val;
        tick(tag);
    endtask

    task automatic drain(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            ack = irq_req;
            tick(tag);
            tick(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_raise = '0; src_enable = '0; prio_wr_en = 1'b0;
        prio_wr_sel = 1'b0; prio_wr_data = '0; ack = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (irq_req !== 1'b0 || irq_id !== 4'd0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%0b/%0d expected=0/0", irq_req, irq_id);
        end
        rst_n = 1'b1;
        src_enable = '1;
        tick("R1 idle after reset");
        tick("R1 idle after reset");

        // R2: disabled source never wins; enable change shows at next edge
        src_enable = 16'h0008;
        src_raise  = 16'h0208;
        tick("R2 raise");
        tick("R2 only enabled source");
        src_enable = 16'h0200;
        tick("R2 enable swap");
        src_enable = 16'h0000;
        tick("R2 all disabled");
        src_enable = '1;
        drain(3, "R2 drain");

        // R3: fixed order, highest index first
        src_raise = 16'h4891;
        tick("R3 raise");
        drain(5, "R3 descending order");

        // R4, R5: promoted sources 2 and 5 beat 12 and 14
        wr_tier(1'b0, 8'h24, "R4 tier write");
        src_raise = 16'h5024;
        tick("R4 raise");
        drain(5, "R5 R4 tiered order");

        // R6: byte writes leave the other byte alone
        wr_tier(1'b0, 8'h01, "R6 low byte");
        src_raise = 16'h8001;
        tick("R6 raise");
        tick("R6 source 0 promoted");
        wr_tier(1'b1, 8'h80, "R6 high byte");
        tick("R6 source 15 promoted");
        wr_tier(1'b0, 8'h00, "R6 low cleared");
        tick("R6 high byte kept");
        drain(3, "R6 drain");
        wr_tier(1'b1, 8'h00, "R6 high cleared");

        // R7, R8: held pending, idle ack ignored
        src_enable = 16'h0000;
        src_raise  = 16'h0040;
        tick("R7 raise masked");
        ack = 1'b1;
        tick("R8 ack while idle");
        ack = 1'b1;
        tick("R8 ack while idle");
        src_enable = '1;
        tick("R7 still pending");
        drain(2, "R8 ack retires");

        // R10: raise collides with ack of the same source
        src_raise = 16'h0100;
        tick("R10 raise");
        tick("R10 reported");
        ack = 1'b1;
        src_raise = 16'h0100;
        tick("R10 collision");
        tick("R10 still pending");
        drain(2, "R10 drain");

        // Mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            src_raise = (($urandom % 4) == 0) ? 16'($urandom) & 16'($urandom) : '0;
            if (($urandom % 16) == 0) src_enable = 16'($urandom);
            if (($urandom % 32) == 0) begin
                prio_wr_en = 1'b1; prio_wr_sel = 1'($urandom); prio_wr_data = 8'($urandom);
            end
            ack = irq_req && (($urandom % 2) == 0);
            tick("R3 R4 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule